// File: doc/BRIEF.md
# Interrupt Source P/Q State Controller

This block holds a two-bit state for every interrupt source in a small bank and serves it through memory-style load and store accesses. Bit 1 of the state (value 2) marks a source as pending. Bit 0 (value 1) marks it as either queued behind an earlier event or masked. For most accesses the operation comes from the address offset inside the source's page, not from any data. A load at a special offset replaces the state and returns the old bits, which lets software unmask a source, mask it, or finish an interrupt.

Triggers come from a per-source hardware pulse or from a store anywhere in the source's trigger page. Each trigger follows the P/Q rules. When a trigger is accepted, the block raises a one-cycle notification for that source toward the event queue logic. A trigger that arrives while the source is already pending is folded into the Q bit. A store-EOI with Q set replays that deferred trigger. Queue writing and routing belong to other blocks.

Top module: `esb_pq_ctrl`

## Requirements
- R1: After reset every source is in state 01 (masked).
- R2: A load at offset 0xC00 of a source's EOI page returns the old state and sets the state to 00.
- R3: A load at offset 0xD00 of the EOI page returns the old state and sets the state to 01.
- R4: A load at offset 0x000 of the EOI page (level-source EOI) returns the old state and sets the state to 00.
- R5: A trigger on state 00 moves it to 10 and pulses that source's notify bit one cycle later. A trigger on 10 moves it to 11, and a trigger on 11 leaves it at 11; neither of these notifies.
- R6: A trigger on state 01 is dropped: the state stays 01 and no notification is raised.
- R7: A store at offset 0x400 of the EOI page sets the state to 00 when Q is clear. When Q is set, it sets the state to 10 and pulses a notification.
- R8: A store at any offset of a source's trigger page acts as one trigger on that source.
- R9: Every load asserts rdValid in the next cycle with the old state in rdData[1:0] and all other bits zero. A load at any offset other than 0xC00, 0xD00 and 0x000 leaves the state unchanged.
- R10: When an access and a trigger hit the same source in the same cycle, the access is applied first and the trigger then acts on the result.
- R11: A store to the EOI page at any offset other than 0x400 has no effect on state or notifications.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe, one cycle per access |
| accWrite | input | 1 | 1 = store, 0 = load |
| accTrigPage | input | 1 | 1 = trigger page, 0 = EOI page |
| accSrc | input | SRC_W | Source index (page number) |
| accOffset | input | 12 | Offset inside the page |
| hwTrig | input | NUM_SRC | Hardware trigger pulses, one bit per source |
| rdValid | output | 1 | Load data valid, one cycle after the load |
| rdData | output | RD_W | Old P/Q state in bits 1:0, other bits zero |
| notify | output | NUM_SRC | One-cycle notification per source |

## Verification
The assertions check, on every cycle, the load response: its timing, its zero upper bits, and that it returns the state the source held when the load was issued. They also check, for every source, that a trigger on a masked source stays silent and that an undisturbed trigger on an idle source notifies and goes pending. The scoreboard scenarios are what show the rest. They cover the offset-selected state writes, the store-EOI replay of a deferred trigger, trigger-page stores at arbitrary offsets, ignored EOI-page stores, and same-cycle ordering of an access against a trigger.

// File: rtl/esb_pq_pkg.sv
package esb_pq_pkg;
  localparam logic [11:0] OFF_LVL_EOI = 12'h000;
  localparam logic [11:0] OFF_ST_EOI  = 12'h400;
  localparam logic [11:0] OFF_CLEAR   = 12'hC00;
  localparam logic [11:0] OFF_MASK    = 12'hD00;

  localparam logic [1:0] PQ_IDLE   = 2'b00;
  localparam logic [1:0] PQ_MASKED = 2'b01;
  localparam logic [1:0] PQ_PEND   = 2'b10;
  localparam logic [1:0] PQ_PENDQ  = 2'b11;

  typedef enum logic [1:0] {
    OP_KEEP  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_MASK  = 2'd2,
    OP_STEOI = 2'd3
  } pqOp_e;

  typedef struct packed {
    logic  rd;
    pqOp_e op;
    logic  swTrig;
  } pqStrobe_t;
endpackage

// File: rtl/esb_pq_decode.sv
module esb_pq_decode
  import esb_pq_pkg::*;
(
  input  logic        accValid,
  input  logic        accWrite,
  input  logic        accTrigPage,
  input  logic [11:0] accOffset,
  output pqStrobe_t   strb
);
  always_comb begin
    strb = '{rd: 1'b0, op: OP_KEEP, swTrig: 1'b0};
    if (accValid) begin
      if (!accWrite) begin
        strb.rd = 1'b1;
        if (!accTrigPage) begin
          if (accOffset == OFF_CLEAR || accOffset == OFF_LVL_EOI) strb.op = OP_CLEAR;
          else if (accOffset == OFF_MASK) strb.op = OP_MASK;
        end
      end else if (accTrigPage) begin
        strb.swTrig = 1'b1;
      end else if (accOffset == OFF_ST_EOI) begin
        strb.op = OP_STEOI;
      end
    end
  end
endmodule

// File: rtl/esb_pq_state.sv
module esb_pq_state
  import esb_pq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int RD_W    = 8,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pqStrobe_t            strb,
  input  logic [SRC_W-1:0]     accSrc,
  input  logic [NUM_SRC-1:0]   hwTrig,
  output logic                 rdValid,
  output logic [RD_W-1:0]      rdData,
  output logic [NUM_SRC-1:0]   notify,
  output logic [2*NUM_SRC-1:0] pqFlat
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [1:0] pqQ, pqMid, pqNxt;
    logic       hit, trig, emitEoi, emitTrig;

    assign hit  = (accSrc == SRC_W'(i));
    assign trig = hwTrig[i] | (hit & strb.swTrig);

    always_comb begin
      pqMid   = pqQ;
      emitEoi = 1'b0;
      if (hit) begin
        unique case (strb.op)
          OP_CLEAR: pqMid = PQ_IDLE;
          OP_MASK:  pqMid = PQ_MASKED;
          OP_STEOI: begin
            pqMid   = pqQ[0] ? PQ_PEND : PQ_IDLE;
            emitEoi = pqQ[0];
          end
          default:  pqMid = pqQ;
        endcase
      end
      pqNxt    = pqMid;
      emitTrig = 1'b0;
      if (trig) begin
        if (pqMid == PQ_IDLE) begin
          pqNxt    = PQ_PEND;
          emitTrig = 1'b1;
        end else if (pqMid == PQ_PEND) begin
          pqNxt = PQ_PENDQ;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pqQ       <= PQ_MASKED;
        notify[i] <= 1'b0;
      end else begin
        pqQ       <= pqNxt;
        notify[i] <= emitEoi | emitTrig;
      end
    end

    assign pqFlat[2*i +: 2] = pqQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rd;
      if (strb.rd) rdData <= {{(RD_W-2){1'b0}}, pqFlat[{accSrc, 1'b0} +: 2]};
    end
  end
endmodule

// File: rtl/esb_pq_ctrl.sv
module esb_pq_ctrl
  import esb_pq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int RD_W    = 8,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic               accWrite,
  input  logic               accTrigPage,
  input  logic [SRC_W-1:0]   accSrc,
  input  logic [11:0]        accOffset,
  input  logic [NUM_SRC-1:0] hwTrig,
  output logic               rdValid,
  output logic [RD_W-1:0]    rdData,
  output logic [NUM_SRC-1:0] notify
);
  pqStrobe_t            strb;
  logic [2*NUM_SRC-1:0] pqFlat;

  esb_pq_decode u_dec (
    .accValid(accValid), .accWrite(accWrite), .accTrigPage(accTrigPage),
    .accOffset(accOffset), .strb(strb)
  );

  esb_pq_state #(.NUM_SRC(NUM_SRC), .RD_W(RD_W)) u_st (
    .clk(clk), .rstN(rstN), .strb(strb), .accSrc(accSrc), .hwTrig(hwTrig),
    .rdValid(rdValid), .rdData(rdData), .notify(notify), .pqFlat(pqFlat)
  );
endmodule

// File: rtl/esb_pq_chk.sv
module esb_pq_chk #(
  parameter int NUM_SRC = 16,
  parameter int RD_W    = 8,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 accValid,
  input logic                 accWrite,
  input logic [SRC_W-1:0]     accSrc,
  input logic [NUM_SRC-1:0]   hwTrig,
  input logic                 rdValid,
  input logic [RD_W-1:0]      rdData,
  input logic [NUM_SRC-1:0]   notify,
  input logic [2*NUM_SRC-1:0] pqFlat
);
  // R9
  load_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite) |=> rdValid);
  // R9
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(accValid && !accWrite) |=> !rdValid);
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[RD_W-1:2] == '0));
  // R9
  old_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite) |=> (rdData[1:0] == $past(pqFlat[{accSrc, 1'b0} +: 2])));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R6
    masked_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pqFlat[2*i +: 2] == 2'b01 && !(accValid && accSrc == SRC_W'(i))) |=>
        (!notify[i] && pqFlat[2*i +: 2] == 2'b01));
    // R5
    idle_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pqFlat[2*i +: 2] == 2'b00 && hwTrig[i] && !(accValid && accSrc == SRC_W'(i))) |=>
        (notify[i] && pqFlat[2*i +: 2] == 2'b10));
  end
endmodule

bind esb_pq_ctrl esb_pq_chk #(.NUM_SRC(NUM_SRC), .RD_W(RD_W)) u_chk (.*);

// File: tb/sim_esb_pq_ctrl.sv
module sim_esb_pq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 16;
  localparam int RW   = 8;
  localparam int SW   = 4;

  typedef struct {
    bit          rdv;
    logic [1:0]  rd;
    logic [N-1:0] ntf;
    string       tag;
  } exp_t;

  logic clk = 0, rstN = 0;
  logic accValid = 0, accWrite = 0, accTrigPage = 0;
  logic [SW-1:0] accSrc = '0;
  logic [11:0] accOffset = '0;
  logic [N-1:0] hwTrig = '0;
  logic rdValid;
  logic [RW-1:0] rdData;
  logic [N-1:0] notify;

  int checks = 0, fails = 0;
  exp_t expQ[$];
  logic [1:0] model[N];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  esb_pq_ctrl #(.NUM_SRC(N), .RD_W(RW)) u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accTrigPage(accTrigPage), .accSrc(accSrc), .accOffset(accOffset),
    .hwTrig(hwTrig), .rdValid(rdValid), .rdData(rdData), .notify(notify)
  );

  // Driver: one cycle of stimulus, expected result computed from requirements
  task automatic step(input bit av, input bit aw, input bit at, input int src,
                      input logic [11:0] off, input logic [N-1:0] hw, input string tag);
    exp_t e;
    logic [N-1:0] trg;
    @(negedge clk);
    accValid = av; accWrite = aw; accTrigPage = at;
    accSrc = SW'(src); accOffset = off; hwTrig = hw;
    e.rdv = av && !aw; e.rd = '0; e.ntf = '0; e.tag = tag;
    trg = hw;
    if (av) begin
      if (!aw) begin
        e.rd = model[src];
        if (!at && (off == 12'hC00 || off == 12'h000)) model[src] = 2'b00;
        else if (!at && off == 12'hD00) model[src] = 2'b01;
      end else if (at) begin
        trg[src] = 1'b1;
      end else if (off == 12'h400) begin
        if (model[src][0]) begin model[src] = 2'b10; e.ntf[src] = 1'b1; end
        else model[src] = 2'b00;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (trg[i]) begin
        if (model[i] == 2'b00) begin model[i] = 2'b10; e.ntf[i] = 1'b1; end
        else if (model[i] == 2'b10) model[i] = 2'b11;
      end
    end
    expQ.push_back(e);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 12'h000, '0, "idle");
  endtask

  task automatic peek(input int src, input string tag);
    step(1, 0, 0, src, 12'h800, '0, tag);
  endtask

  // Monitor: compares after each edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (rdValid !== e.rdv || notify !== e.ntf || (e.rdv && rdData !== {{(RW-2){1'b0}}, e.rd})) begin
        fails++;
        $display("FAIL %s: rdValid=%0b rdData=%h notify=%h expected rdValid=%0b rdData=%h notify=%h",
                 e.tag, rdValid, rdData, notify, e.rdv, e.rd, e.ntf);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 reset state, R9 plain load does not change it
    peek(0, "R1 src0");
    peek(5, "R1 src5");
    peek(15, "R1 src15");
    peek(0, "R9 plain load keeps state");
    // R6 masked trigger dropped
    step(0, 0, 0, 0, 12'h000, N'(1) << 3, "R6 masked hw trigger");
    peek(3, "R6 state still masked");
    // R2 unmask
    step(1, 0, 0, 3, 12'hC00, '0, "R2 load C00");
    peek(3, "R2 state cleared");
    // R5 trigger sequence
    step(0, 0, 0, 0, 12'h000, N'(1) << 3, "R5 trigger on idle");
    peek(3, "R5 pending");
    step(0, 0, 0, 0, 12'h000, N'(1) << 3, "R5 trigger on pending");
    peek(3, "R5 pending queued");
    step(0, 0, 0, 0, 12'h000, N'(1) << 3, "R5 trigger on 11");
    peek(3, "R5 stays 11");
    // R4 level EOI
    step(1, 0, 0, 3, 12'h000, '0, "R4 load 000");
    peek(3, "R4 state cleared");
    // R7 store EOI
    step(1, 1, 0, 3, 12'h400, '0, "R7 store EOI on 00");
    peek(3, "R7 stays idle");
    step(0, 0, 0, 0, 12'h000, N'(1) << 3, "R7 setup trig");
    step(0, 0, 0, 0, 12'h000, N'(1) << 3, "R7 setup coalesce");
    step(1, 1, 0, 3, 12'h400, '0, "R7 store EOI replay");
    peek(3, "R7 replayed pending");
    step(1, 1, 0, 3, 12'h400, '0, "R7 store EOI Q clear");
    peek(3, "R7 cleared");
    // R8 trigger page store
    step(1, 0, 0, 7, 12'hC00, '0, "R8 unmask src7");
    step(1, 1, 1, 7, 12'h123, '0, "R8 trigger page store");
    step(1, 1, 1, 7, 12'hFF8, '0, "R8 trigger page coalesce");
    peek(7, "R8 state 11");
    // R11 ignored EOI page stores
    step(1, 1, 0, 7, 12'h200, '0, "R11 stray store");
    step(1, 1, 0, 7, 12'hC00, '0, "R11 store at C00");
    peek(7, "R11 state unchanged");
    // R10 same-cycle ordering
    step(1, 0, 0, 9, 12'hC00, N'(1) << 9, "R10 unmask plus trigger");
    peek(9, "R10 pending after");
    step(1, 0, 0, 9, 12'hD00, N'(1) << 9, "R10 mask plus trigger");
    peek(9, "R10 masked after");
    step(1, 1, 0, 3, 12'h400, N'(1) << 3, "R10 store EOI plus trigger");
    peek(3, "R10 pending after EOI");
    // R3 mask
    step(1, 0, 0, 3, 12'hD00, '0, "R3 load D00");
    peek(3, "R3 masked");
    // R5 several sources at once
    step(1, 0, 0, 1, 12'hC00, '0, "R5 unmask src1");
    step(1, 0, 0, 2, 12'hC00, '0, "R5 unmask src2");
    step(0, 0, 0, 0, 12'h000, N'(16'h0007), "R5 multi trigger");
    peek(1, "R5 src1 pending");
    peek(0, "R6 src0 still masked");
    idle();
    idle();
    @(posedge clk); #4;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule